// File: doc/BRIEF.md
# Coprocessor Interrupt and Flags Controller

This block keeps the flags word and the control word of a small RISC coprocessor and decides when, and for which source, an interrupt is taken. Five interrupt sources each set a latch bit inside the control word. Each source also has an enable bit and a write-one-to-clear bit in the flags word. A mask bit in the flags word blocks all servicing while it is set.

When the mask is clear and at least one enabled latch is pending, the block chooses the highest-numbered pending source. It sets the mask and raises a service request carrying the vector address. The vector is the local RAM base plus sixteen bytes per source number. On acknowledge, the core decrements stack register 31 by four, stores PC minus two there, and loads the vector into register 30 and into PC. The latch is not cleared by servicing; software clears it through the flags word. Host software, or a core executing a return, clears the mask with a flags write. Host writes can never set the mask.

A small word-addressed register port gives access to both words. The flags word is at word index 0 and the control word at word index 5. Reads are combinational.

Top module: `copro_irq_ctrl`

## Requirements
- R1: After reset the flags word reads 0x00000000 and the control word reads 0x00002800. `svc_valid`, `host_irq` and `run` are low.
- R2: A control write keeps the bits under 0x0000F7C0 (latches in bits 10:6 and bits 15:12) and stores every other bit except bits 1 and 2, which always read 0. Control bit 0 drives `run`.
- R3: A control write with bit 1 set raises `host_irq` for exactly the following cycle. A control write with bit 2 set sets latch 0 (control bit 6).
- R4: A high `irq_src[k]` at a clock edge sets latch k (control bit 6+k). A latch stays set until it is cleared.
- R5: A flags write with bit 9+k set clears latch k. If a set event for latch k occurs in the same cycle, the set wins.
- R6: Flags reads return bits 13:9 as 0, and bits 2:0 as the current zero, carry and negative values. `core_flag_we` loads those three bits from `core_znc` (bit 0 zero, bit 1 carry, bit 2 negative), and a host flags write takes precedence.
- R7: A flags write with bit 3 at 0 clears the mask. A write with bit 3 at 1 leaves the mask as it was, so a host write never sets it.
- R8: When the mask is 0, no request is outstanding and (latches AND enables in flags bits 8:4) is nonzero, the next edge raises `svc_valid` and sets the mask. `svc_idx` is the highest-numbered pending source. Nothing is serviced while the mask is 1.
- R9: `svc_vector` equals LRAM_BASE + 16 × `svc_idx`. `svc_valid`, `svc_idx` and `svc_vector` hold until `svc_ack` is sampled high, and `svc_valid` is low from the edge that sees `svc_ack`.
- R10: If a flags write clears the mask while an enabled latch is pending, `svc_valid` rises at the very next edge after the write edge.
- R11: `reg_page` equals flags bit 14 while the mask is 0, and is 0 while the mask is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word index (0 flags, 5 control) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| core_flag_we | input | 1 | Core update of the zero/carry/negative flags |
| core_znc | input | 3 | New zero, carry, negative values |
| irq_src | input | 5 | Interrupt source set events |
| svc_ack | input | 1 | Core accepts the service request |
| svc_valid | output | 1 | Service request outstanding |
| svc_idx | output | 3 | Serviced source number |
| svc_vector | output | 32 | Handler entry address |
| host_irq | output | 1 | One-cycle interrupt pulse to the host |
| run | output | 1 | Run/stop control for the core |
| reg_page | output | 1 | Effective register page |

## Verification
Every cycle, the assertions check that a service request is held stable until it is acknowledged, and that the mask only rises together with a new request. They also check that a request never starts while the mask is set, that a latch only falls after a flags write, that the host pulse follows a control write, and that the register page is forced to 0 under the mask. The bench scenarios show the data-dependent results: the exact read-back values after control writes to protected bits, the priority among simultaneous sources, and the vector values. They also show the one-cycle re-evaluation after the mask is cleared, and the set-over-clear rule when both hit a latch in the same cycle.

// File: rtl/copro_irq_pkg.sv
package copro_irq_pkg;
  localparam int NUM_IRQ    = 5;
  localparam int IDX_W      = $clog2(NUM_IRQ);
  localparam int FLG_MASK   = 3;
  localparam int FLG_EN_LSB = 4;
  localparam int FLG_CL_LSB = 9;
  localparam int FLG_PAGE   = 14;
  localparam int CTL_LT_LSB = 6;
  localparam logic [31:0] CTL_PROTECT = 32'h0000_F7C0;
  localparam logic [31:0] CTL_CMDBITS = 32'h0000_0006;
  localparam logic [31:0] CTL_RESET   = 32'h0000_2800;
  localparam logic [31:0] FLG_RDMASK  = 32'hFFFF_C1FF;
  localparam logic [2:0]  WADDR_FLAGS = 3'd0;
  localparam logic [2:0]  WADDR_CTRL  = 3'd5;
endpackage

// File: rtl/copro_flags_reg.sv
module copro_flags_reg
  import copro_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  input  logic               core_we,
  input  logic [2:0]         core_znc,
  input  logic               set_mask,
  output logic [31:0]        flags_q,
  output logic [NUM_IRQ-1:0] clr_req,
  output logic [NUM_IRQ-1:0] enables,
  output logic               mask,
  output logic               page
);
  logic [31:0] flags_d;
  logic        upd_en;

  assign upd_en = wr_en | core_we | set_mask;

  always_comb begin
    flags_d = flags_q;
    if (core_we) flags_d[2:0] = core_znc;
    if (wr_en) begin
      flags_d = wdata;
      flags_d[FLG_CL_LSB +: NUM_IRQ] = '0;
      flags_d[FLG_MASK] = wdata[FLG_MASK] & flags_q[FLG_MASK];
    end
    if (set_mask) flags_d[FLG_MASK] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign clr_req = wr_en ? wdata[FLG_CL_LSB +: NUM_IRQ] : '0;
  assign enables = flags_q[FLG_EN_LSB +: NUM_IRQ];
  assign mask    = flags_q[FLG_MASK];
  assign page    = flags_q[FLG_PAGE] & ~flags_q[FLG_MASK];
endmodule

// File: rtl/copro_ctrl_reg.sv
module copro_ctrl_reg
  import copro_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  input  logic [NUM_IRQ-1:0] irq_src,
  input  logic [NUM_IRQ-1:0] clr_req,
  output logic [31:0]        ctrl_q,
  output logic [NUM_IRQ-1:0] latches,
  output logic               host_irq,
  output logic               run
);
  logic [31:0]        ctrl_d;
  logic [NUM_IRQ-1:0] set_ev;
  logic               host_d;

  always_comb begin
    set_ev    = irq_src;
    set_ev[0] = irq_src[0] | (wr_en & wdata[2]);
    ctrl_d    = ctrl_q;
    if (wr_en)
      ctrl_d = (ctrl_q & CTL_PROTECT) | (wdata & ~CTL_PROTECT & ~CTL_CMDBITS);
    ctrl_d[CTL_LT_LSB +: NUM_IRQ] =
      (ctrl_q[CTL_LT_LSB +: NUM_IRQ] & ~clr_req) | set_ev;
    host_d = wr_en & wdata[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTL_RESET;
      host_irq <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      host_irq <= host_d;
    end
  end

  assign latches = ctrl_q[CTL_LT_LSB +: NUM_IRQ];
  assign run     = ctrl_q[0];
endmodule

// File: rtl/copro_irq_arb.sv
module copro_irq_arb
  import copro_irq_pkg::*;
#(
  parameter logic [31:0] LRAM_BASE = 32'h00F0_3000,
  parameter int          VEC_LG2   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask,
  input  logic [NUM_IRQ-1:0] latches,
  input  logic [NUM_IRQ-1:0] enables,
  input  logic               ack,
  output logic               grant,
  output logic               valid_q,
  output logic [IDX_W-1:0]   idx_q,
  output logic [31:0]        vector
);
  logic [NUM_IRQ-1:0] pending;
  logic [IDX_W-1:0]   pick;
  logic               valid_d;

  always_comb begin
    pending = latches & enables;
    pick    = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (pending[i]) pick = IDX_W'(i);
    grant   = ~mask & ~valid_q & (|pending);
    valid_d = valid_q;
    if (grant)    valid_d = 1'b1;
    else if (ack) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (grant) idx_q <= pick;
    end
  end

  assign vector = LRAM_BASE + (32'(idx_q) << VEC_LG2);
endmodule

// File: rtl/copro_irq_ctrl.sv
module copro_irq_ctrl
  import copro_irq_pkg::*;
#(
  parameter logic [31:0] LRAM_BASE = 32'h00F0_3000,
  parameter int          VEC_LG2   = 4,
  parameter int          ADDR_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               core_flag_we,
  input  logic [2:0]         core_znc,
  input  logic [NUM_IRQ-1:0] irq_src,
  input  logic               svc_ack,
  output logic               svc_valid,
  output logic [IDX_W-1:0]   svc_idx,
  output logic [31:0]        svc_vector,
  output logic               host_irq,
  output logic               run,
  output logic               reg_page
);
  logic [1:0]         rst_sync;
  logic               rst_ni;
  logic               flags_wr, ctrl_wr, grant, mask_q;
  logic [31:0]        flags_q, ctrl_q;
  logic [NUM_IRQ-1:0] clr_req, enables, latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign flags_wr = bus_wr && (bus_addr == ADDR_W'(WADDR_FLAGS));
  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(WADDR_CTRL));

  copro_flags_reg u_flags (
    .clk(clk), .rst_n(rst_ni), .wr_en(flags_wr), .wdata(bus_wdata),
    .core_we(core_flag_we), .core_znc(core_znc), .set_mask(grant),
    .flags_q(flags_q), .clr_req(clr_req), .enables(enables),
    .mask(mask_q), .page(reg_page)
  );

  copro_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_ni), .wr_en(ctrl_wr), .wdata(bus_wdata),
    .irq_src(irq_src), .clr_req(clr_req), .ctrl_q(ctrl_q),
    .latches(latch_q), .host_irq(host_irq), .run(run)
  );

  copro_irq_arb #(.LRAM_BASE(LRAM_BASE), .VEC_LG2(VEC_LG2)) u_arb (
    .clk(clk), .rst_n(rst_ni), .mask(mask_q), .latches(latch_q),
    .enables(enables), .ack(svc_ack), .grant(grant),
    .valid_q(svc_valid), .idx_q(svc_idx), .vector(svc_vector)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(WADDR_FLAGS)) bus_rdata = flags_q & FLG_RDMASK;
    else if (bus_addr == ADDR_W'(WADDR_CTRL)) bus_rdata = ctrl_q;
  end
endmodule

// File: rtl/copro_irq_ctrl_chk.sv
module copro_irq_ctrl_chk
  import copro_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               host_bit,
  input logic               host_irq,
  input logic               svc_valid,
  input logic               svc_ack,
  input logic [31:0]        svc_vector,
  input logic               reg_page,
  input logic               mask_q,
  input logic [NUM_IRQ-1:0] latches
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && !svc_ack) |=> (svc_valid && $stable(svc_vector)));

  assert_drop_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && svc_ack) |=> !svc_valid);

  assert_mask_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_valid) |-> (mask_q && !$past(mask_q)));

  assert_mask_rise_only_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_q) |-> $rose(svc_valid));

  assert_host_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(bus_wr && bus_addr == ADDR_W'(WADDR_CTRL) && host_bit));

  assert_latch_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(latches) & ~latches)) |-> $past(bus_wr && bus_addr == ADDR_W'(WADDR_FLAGS)));

  assert_page_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !reg_page);
endmodule

bind copro_irq_ctrl copro_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .host_bit(bus_wdata[1]), .host_irq(host_irq), .svc_valid(svc_valid),
  .svc_ack(svc_ack), .svc_vector(svc_vector), .reg_page(reg_page),
  .mask_q(mask_q), .latches(latch_q)
);

// File: tb/tb_copro_irq_ctrl.sv
`timescale 1ns/100ps
module tb_copro_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        core_flag_we;
  logic [2:0]  core_znc;
  logic [4:0]  irq_src;
  logic        svc_ack, svc_valid, host_irq, run, reg_page;
  logic [2:0]  svc_idx;
  logic [31:0] svc_vector;
  int          n_tests = 0, n_fail = 0, cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  copro_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_flag_we(core_flag_we),
    .core_znc(core_znc), .irq_src(irq_src), .svc_ack(svc_ack),
    .svc_valid(svc_valid), .svc_idx(svc_idx), .svc_vector(svc_vector),
    .host_irq(host_irq), .run(run), .reg_page(reg_page)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ack_req();
    svc_ack = 1'b1; @(negedge clk); svc_ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 flags", v, 32'h0);
    rd(3'd5, v); chk("R1 ctrl", v, 32'h2800);
    chk("R1 outputs", {svc_valid, host_irq, run}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R3 host pulse", host_irq, 1);
    rd(3'd5, v); chk("R2 R3 ctrl protect+irq0", v, 32'hFFFF_2879);
    chk("R2 run", run, 1);
    @(negedge clk);
    chk("R3 pulse width", host_irq, 0);
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R2 latch kept", v, 32'h2040);
    chk("R2 run off", run, 0);
    wr(3'd0, 32'h200);
    rd(3'd5, v); chk("R5 clear latch0", v, 32'h2000);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    core_flag_we = 1'b1; core_znc = 3'b101; @(negedge clk); core_flag_we = 1'b0;
    rd(3'd0, v); chk("R6 live znc", v, 32'h5);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R6 R7 flags readback", v, 32'hFFFF_C1F7);
    chk("R11 page", reg_page, 1);
    @(negedge clk);
    chk("R8 no pending", svc_valid, 0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(3'd0, 32'h41F0);
    irq_src = 5'b01010; @(negedge clk); irq_src = 5'b0;
    rd(3'd5, v); chk("R4 latches", v, 32'h2280);
    chk("R8 not yet", svc_valid, 0);
    @(negedge clk);
    chk("R8 valid", svc_valid, 1);
    chk("R8 highest idx", svc_idx, 3);
    chk("R9 vector", svc_vector, 32'h00F0_3030);
    rd(3'd0, v); chk("R8 mask set", v, 32'h41F8);
    chk("R11 page masked", reg_page, 0);
    irq_src = 5'b10000; @(negedge clk); irq_src = 5'b0;
    repeat (2) @(negedge clk);
    chk("R9 hold valid", svc_valid, 1);
    chk("R9 hold vector", svc_vector, 32'h00F0_3030);
    ack_req();
    chk("R9 drop after ack", svc_valid, 0);
    repeat (3) @(negedge clk);
    chk("R8 masked no service", svc_valid, 0);
    wr(3'd0, 32'h41F8 | 32'h3000);
    rd(3'd0, v); chk("R7 mask kept", v, 32'h41F8);
    rd(3'd5, v); chk("R5 clear 3 and 4", v, 32'h2080);
    wr(3'd0, 32'h41F0);
    chk("R10 not same cycle", svc_valid, 0);
    chk("R11 page unmasked", reg_page, 1);
    @(negedge clk);
    chk("R10 valid next edge", svc_valid, 1);
    chk("R9 vector idx1", svc_vector, 32'h00F0_3010);
    ack_req();
    wr(3'd0, 32'h1F0 | 32'h400);
    @(negedge clk);
    chk("R8 idle after clear", svc_valid, 0);
    rd(3'd0, v); chk("R7 flags", v, 32'h1F0);
  endtask

  task automatic t_irq0();
    logic [31:0] v;
    wr(3'd5, 32'h4);
    chk("R3 no host pulse", host_irq, 0);
    @(negedge clk);
    chk("R3 irq0 serviced", svc_valid, 1);
    chk("R9 vector idx0", svc_vector, 32'h00F0_3000);
    ack_req();
    irq_src = 5'b00001;
    wr(3'd0, 32'h1F8 | 32'h200);
    irq_src = 5'b0;
    rd(3'd5, v); chk("R5 set wins", v, 32'h2040);
    wr(3'd0, 32'h1F8 | 32'h200);
    rd(3'd5, v); chk("R5 cleared", v, 32'h2000);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: got %0d expected < 20000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    core_flag_we = 1'b0; core_znc = '0; irq_src = '0; svc_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl();
    t_flags();
    t_priority();
    t_irq0();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule